// File: doc/BRIEF.md
# Eight-Channel Interrupt Register Bank with Broadcast Write

This block holds the interrupt registers for eight identical channels that share one parallel host bus. A 12-bit address is split into a 4-bit channel selector in the upper bits and an 8-bit register offset in the low byte. Selector values 0 to 7 reach one channel. Selector 8 is a broadcast code: a write there lands in the same register of all eight channels at once. Selector 15 reaches the two registers that are global and exist only once.

Each channel has three registers. The first is a sticky status register, set by single-cycle event pulses from the line-side logic and cleared when the host reads it. The second is a mask register. The third is a control register whose bit 0 is a software reset. Each channel drives one interrupt line. The line is high when any status bit is set together with its mask bit, and when that channel's bit in the shared global mask is also set.

Registers return to their reset values in three cases: on the asynchronous reset input, on a software-reset falling edge within one channel, and on any write to the global control register.

Top module: `mcrb_top`

## Requirements
- R1: A write with selector `addr[11:8]` in 0..7 changes only that channel's register. A read with such a selector returns only that channel's register. Channel offsets: status at 0x33 (alias 0x23), mask at 0x43, control at 0xF1.
- R2: A write with selector 8 updates the addressed register (mask or control) in all eight channels in the same cycle.
- R3: A read with selector 8 returns zero. A read of an unmapped address, such as selector 9, also returns zero.
- R4: A one-cycle pulse on a channel's `evt` bit sets the matching status bit. The bit stays set until a clearing read or a reset. Status bits are set only by events.
- R5: A read at offset 0x33 or 0x23 returns the status value and clears it. If an event arrives in the same cycle as the clearing read, that event's bit stays set.
- R6: `irq[k]` is high exactly when channel k has some status bit set together with its mask bit and global mask bit k is 1. The global mask is one shared register at address 0xF01 (bit k for channel k).
- R7: After the reset input is asserted (active low, asynchronous), status, mask and control read 0, global control reads 0, global mask reads 0xFF, and `irq` is 0.
- R8: A control write that takes bit 0 from 1 to 0 clears that channel's status and mask. Other channels are unaffected. A control write that does not make this 1-to-0 transition clears nothing.
- R9: Any write to global control at address 0xF00 restores the reset values of every channel register and of the global mask. Global control itself takes the written value.
- R10: Read data appears on `rdData` in the cycle after `rdEn` is sampled. In cycles with no read, `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 12 | Channel selector [11:8], register offset [7:0] |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| rdEn | input | 1 | Read strobe, sampled on the rising edge |
| wrData | input | 16 | Write data |
| evt | input | 72 | Event pulses, channel k in bits [9k+8:9k] |
| rdData | output | 16 | Registered read data |
| irq | output | 8 | Per-channel interrupt lines |

## Verification
The hardest case to reach is an event pulse that arrives in the same clock edge as the clearing read of the same status register. Only this case shows whether the set or the clear wins. The bench drives `evt` and `rdEn` from one negative edge so that both are sampled on the same rising edge. It expects the read to return the older value and a follow-up read to still show the new bit. Software reset is hard to isolate for the same reason. The bench arms one channel, loads events into two channels, then drops the reset bit and confirms that only the armed channel lost its state. It also confirms that a repeated zero write to an unarmed channel does nothing.

// File: rtl/mcrb_pkg.sv
`timescale 1ns/1ps
package mcrb_pkg;
  localparam int NUM_CH  = 8;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int SEL_W   = 4;
  localparam int OFF_W   = 8;
  localparam int ADDR_W  = SEL_W + OFF_W;
  localparam int DATA_W  = 16;
  localparam int STAT_W  = 9;
  localparam int EVT_W   = NUM_CH * STAT_W;
  localparam int SWRST_BIT = 0;

  localparam logic [SEL_W-1:0] SEL_BCAST  = 4'h8;
  localparam logic [SEL_W-1:0] SEL_GLOBAL = 4'hF;

  localparam logic [OFF_W-1:0] OFF_STAT_A = 8'h33;
  localparam logic [OFF_W-1:0] OFF_STAT_B = 8'h23;
  localparam logic [OFF_W-1:0] OFF_MASK   = 8'h43;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 8'hF1;
  localparam logic [OFF_W-1:0] OFF_GCTRL  = 8'h00;
  localparam logic [OFF_W-1:0] OFF_GMASK  = 8'h01;

  localparam logic [NUM_CH-1:0] GMASK_RST = '1;

  typedef enum logic [2:0] {
    RD_NONE, RD_STAT, RD_MASK, RD_CTRL, RD_GCTRL, RD_GMASK
  } rdKind_e;

  typedef struct packed {
    logic [NUM_CH-1:0] wrMask;
    logic [NUM_CH-1:0] wrCtrl;
    logic [NUM_CH-1:0] rdClr;
    logic              wrGCtrl;
    logic              wrGMask;
    rdKind_e           rdKind;
    logic [CH_W-1:0]   rdCh;
  } strobe_t;
endpackage

// File: rtl/mcrb_ctrl.sv
`timescale 1ns/1ps
module mcrb_ctrl
  import mcrb_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobe_t           stb
);
  logic [SEL_W-1:0] sel;
  logic [OFF_W-1:0] off;
  logic chHit, isBcast, isGlobal, isStat;

  assign sel      = addr[ADDR_W-1:OFF_W];
  assign off      = addr[OFF_W-1:0];
  assign chHit    = sel < SEL_W'(NUM_CH);
  assign isBcast  = sel == SEL_BCAST;
  assign isGlobal = sel == SEL_GLOBAL;
  assign isStat   = (off == OFF_STAT_A) || (off == OFF_STAT_B);

  always_comb begin
    stb = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      // a broadcast write reaches every channel, a plain one only its own
      if (wrEn && ((chHit && sel == SEL_W'(k)) || isBcast)) begin
        stb.wrMask[k] = off == OFF_MASK;
        stb.wrCtrl[k] = off == OFF_CTRL;
      end
      stb.rdClr[k] = rdEn && chHit && sel == SEL_W'(k) && isStat;
    end
    stb.wrGCtrl = wrEn && isGlobal && off == OFF_GCTRL;
    stb.wrGMask = wrEn && isGlobal && off == OFF_GMASK;
    stb.rdCh    = sel[CH_W-1:0];
    if (rdEn && chHit) begin
      if (isStat)                stb.rdKind = RD_STAT;
      else if (off == OFF_MASK)  stb.rdKind = RD_MASK;
      else if (off == OFF_CTRL)  stb.rdKind = RD_CTRL;
    end else if (rdEn && isGlobal) begin
      if (off == OFF_GCTRL)      stb.rdKind = RD_GCTRL;
      else if (off == OFF_GMASK) stb.rdKind = RD_GMASK;
    end
  end
endmodule

// File: rtl/mcrb_dp.sv
`timescale 1ns/1ps
module mcrb_dp
  import mcrb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  strobe_t           stb,
  input  logic [EVT_W-1:0]  evt,
  output logic [NUM_CH-1:0] irq,
  output logic [DATA_W-1:0] rdData,
  output logic [EVT_W-1:0]  statusFlat,
  output logic [NUM_CH-1:0] gMask
);
  logic [STAT_W-1:0] statArr [NUM_CH];
  logic [STAT_W-1:0] maskArr [NUM_CH];
  logic [DATA_W-1:0] ctrlArr [NUM_CH];
  logic [DATA_W-1:0] gCtrl;
  logic [DATA_W-1:0] rdNext;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [STAT_W-1:0] stat, mask;
    logic [DATA_W-1:0] ctrl;
    logic [STAT_W-1:0] chEvt;
    logic swFall, chRst;

    assign chEvt  = evt[k*STAT_W +: STAT_W];
    assign swFall = stb.wrCtrl[k] && ctrl[SWRST_BIT] && !wrData[SWRST_BIT];
    assign chRst  = swFall || stb.wrGCtrl;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stat <= '0;
        mask <= '0;
        ctrl <= '0;
      end else if (chRst) begin
        stat <= '0;
        mask <= '0;
        ctrl <= stb.wrCtrl[k] ? wrData : '0;
      end else begin
        // a new event outranks a clear in the same cycle
        stat <= (stat & ~{STAT_W{stb.rdClr[k]}}) | chEvt;
        if (stb.wrMask[k]) mask <= wrData[STAT_W-1:0];
        if (stb.wrCtrl[k]) ctrl <= wrData;
      end
    end

    assign statArr[k] = stat;
    assign maskArr[k] = mask;
    assign ctrlArr[k] = ctrl;
    assign statusFlat[k*STAT_W +: STAT_W] = stat;
    assign irq[k] = (|(stat & mask)) & gMask[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gCtrl <= '0;
      gMask <= GMASK_RST;
    end else begin
      if (stb.wrGCtrl) begin
        gCtrl <= wrData;
        gMask <= GMASK_RST;
      end else if (stb.wrGMask) begin
        gMask <= wrData[NUM_CH-1:0];
      end
    end
  end

  always_comb begin
    case (stb.rdKind)
      RD_STAT:  rdNext = DATA_W'(statArr[stb.rdCh]);
      RD_MASK:  rdNext = DATA_W'(maskArr[stb.rdCh]);
      RD_CTRL:  rdNext = ctrlArr[stb.rdCh];
      RD_GCTRL: rdNext = gCtrl;
      RD_GMASK: rdNext = DATA_W'(gMask);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end
endmodule

// File: rtl/mcrb_top.sv
`timescale 1ns/1ps
module mcrb_top
  import mcrb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [15:0]       wrData,
  input  logic [71:0]       evt,
  output logic [15:0]       rdData,
  output logic [7:0]        irq
);
  strobe_t           stb;
  logic [EVT_W-1:0]  statusFlat;
  logic [NUM_CH-1:0] gMask;

  mcrb_ctrl u_ctrl (
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .stb  (stb)
  );

  mcrb_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrData     (wrData),
    .stb        (stb),
    .evt        (evt),
    .irq        (irq),
    .rdData     (rdData),
    .statusFlat (statusFlat),
    .gMask      (gMask)
  );
endmodule

// File: rtl/mcrb_chk.sv
`timescale 1ns/1ps
module mcrb_chk
  import mcrb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [EVT_W-1:0]  evt,
  input logic [NUM_CH-1:0] irq,
  input logic [DATA_W-1:0] rdData,
  input logic [EVT_W-1:0]  statusFlat,
  input logic [NUM_CH-1:0] gMask
);
  // R4
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && evt != '0) |=> ((statusFlat & $past(evt)) == $past(evt)));

  // R4
  status_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusFlat != $past(statusFlat)) |->
      ((statusFlat & ~$past(statusFlat) & ~$past(evt)) == '0));

  // R3
  bcast_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[ADDR_W-1:OFF_W] == SEL_BCAST) |=> (rdData == '0));

  // R9
  gctrl_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == {SEL_GLOBAL, OFF_GCTRL}) |=> (statusFlat == '0 && gMask == GMASK_RST));

  // R6
  gmask_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gMask != GMASK_RST) |-> ((irq & ~gMask) == '0));

  // R10
  idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == '0));
endmodule

bind mcrb_top mcrb_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .addr       (addr),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .evt        (evt),
  .irq        (irq),
  .rdData     (rdData),
  .statusFlat (statusFlat),
  .gMask      (gMask)
);

// File: tb/mcrb_top_tb.sv
`timescale 1ns/1ps
module mcrb_top_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic [11:0] addr = '0;
  logic        wrEn = 0;
  logic        rdEn = 0;
  logic [15:0] wrData = '0;
  logic [71:0] evt = '0;
  logic [15:0] rdData;
  logic [7:0]  irq;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;
  bit rdSeen  = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  mcrb_top u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .evt(evt), .rdData(rdData), .irq(irq)
  );

  always @(posedge clk) rdSeen <= rdEn;

  // monitor: read data is due one edge after rdEn was sampled (R10)
  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      logic [15:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      vectors++;
      if (rdData !== e) begin
        misses++;
        $display("FAIL %s rdData got %h exp %h", t, rdData, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    addr = a; rdEn = 1;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    rdEn = 0;
  endtask

  task automatic pulse(input int ch, input logic [8:0] b);
    @(negedge clk);
    evt[ch*9 +: 9] = b;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic chkIrq(input logic [7:0] e, input string t);
    vectors++;
    if (irq !== e) begin
      misses++;
      $display("FAIL %s irq got %h exp %h", t, irq, e);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  initial begin
    #800000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;

    // R7 reset values
    chkIrq(8'h00, "R7");
    rd(12'h033, 16'h0000, "R7 status");
    rd(12'h043, 16'h0000, "R7 mask");
    rd(12'h0F1, 16'h0000, "R7 ctrl");
    rd(12'hF01, 16'h00FF, "R7 gmask");
    rd(12'hF00, 16'h0000, "R7 gctrl");

    // R1 single channel write
    wr(12'h343, 16'h00A5);
    rd(12'h343, 16'h00A5, "R1 ch3 mask");
    rd(12'h243, 16'h0000, "R1 ch2 untouched");

    // R2 broadcast write
    wr(12'h843, 16'h0003);
    rd(12'h043, 16'h0003, "R2 ch0 mask");
    rd(12'h743, 16'h0003, "R2 ch7 mask");
    rd(12'h343, 16'h0003, "R2 ch3 mask");

    // R3 broadcast read and unmapped read
    rd(12'h843, 16'h0000, "R3 bcast read");
    rd(12'h9F0, 16'h0000, "R3 unmapped");

    // R4 sticky, R5 clear on read through both aliases
    pulse(5, 9'h001);
    pulse(5, 9'h100);
    rd(12'h533, 16'h0101, "R4 sticky");
    rd(12'h523, 16'h0000, "R5 cleared");
    pulse(5, 9'h020);
    rd(12'h523, 16'h0020, "R5 alias read");
    rd(12'h533, 16'h0000, "R5 alias cleared");

    // R6 interrupt and global mask gating
    pulse(1, 9'h002);
    chkIrq(8'h02, "R6 masked-in event");
    pulse(1, 9'h004);
    chkIrq(8'h02, "R6 masked-out event");
    pulse(6, 9'h004);
    chkIrq(8'h02, "R6 masked-out other ch");
    rd(12'h633, 16'h0004, "R6 ch6 status");
    wr(12'hF01, 16'h00FD);
    chkIrq(8'h00, "R6 gmask off");
    wr(12'hF01, 16'h00FF);
    chkIrq(8'h02, "R6 gmask on");
    rd(12'h123, 16'h0006, "R6 status");
    chkIrq(8'h00, "R6 after clear");

    // R5 event in the same cycle as the clearing read
    pulse(2, 9'h010);
    @(negedge clk);
    evt[2*9 +: 9] = 9'h010; addr = 12'h233; rdEn = 1;
    expQ.push_back(16'h0010); tagQ.push_back("R5 collide read");
    @(negedge clk);
    rdEn = 0; evt = '0;
    rd(12'h233, 16'h0010, "R5 event kept");
    rd(12'h233, 16'h0000, "R5 then cleared");

    // R8 software reset on falling bit 0
    wr(12'h4F1, 16'h0001);
    pulse(4, 9'h001);
    pulse(6, 9'h001);
    wr(12'h4F1, 16'h0000);
    rd(12'h433, 16'h0000, "R8 ch4 status");
    rd(12'h443, 16'h0000, "R8 ch4 mask");
    rd(12'h4F1, 16'h0000, "R8 ch4 ctrl");
    rd(12'h643, 16'h0003, "R8 ch6 mask kept");
    wr(12'h6F1, 16'h0000);
    rd(12'h643, 16'h0003, "R8 no-fall no reset");
    rd(12'h633, 16'h0001, "R8 ch6 status kept");

    // R9 global control write restores reset values
    pulse(0, 9'h001);
    wr(12'hF01, 16'h000F);
    wr(12'hF00, 16'h8000);
    rd(12'hF00, 16'h8000, "R9 gctrl value");
    rd(12'hF01, 16'h00FF, "R9 gmask reset");
    rd(12'h043, 16'h0000, "R9 ch0 mask");
    rd(12'h033, 16'h0000, "R9 ch0 status");
    rd(12'h743, 16'h0000, "R9 ch7 mask");
    chkIrq(8'h00, "R9 irq");

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule